// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block gathers sixteen primary interrupt inputs and a small extension bank of three sources. It turns them into two registered request lines for a processor: a fast request and a normal request. The four lowest primary sources feed only the fast line. Every other enabled source feeds the normal line, including the enabled extension sources. Each source is gated by its own enable bit, held in a mask register that software writes over a simple register bus. Status registers show the raw activity of every source, whatever the mask holds.

The extension bank holds three sources:

- A keyboard source. It ORs either the lowest six or all eight port input lines, as a configuration input selects. It latches on any high level, however short, and stays set until software writes to a dedicated end-of-interrupt address.
- A serial-receive source. It follows the fill count of an external receive FIFO. It rises at a threshold of eight entries and falls only when the FIFO empties, or on the first serial clock tick after the receiver is disabled.
- A serial-transmit level input, passed straight through.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, both mask registers read 0 and both fiq and irq are low.
- R2: The primary mask register (address 1, 16 bits) can be written and read back. A 1 in bit n enables primary source n. Reads return data on the clock after the read request.
- R3: Primary sources 0 to 3, when enabled, drive fiq and never irq. fiq follows the masked sources one clock later.
- R4: Primary sources 4 to 15, when enabled, drive irq and never fiq, one clock later.
- R5: The primary status register (address 0) returns the raw source levels whatever the mask holds. Writes to address 0 or address 2 change no state.
- R6: The keyboard source is the OR of kbd_in[5:0] when kbd_use8 is 0, and of kbd_in[7:0] when kbd_use8 is 1.
- R7: A single-cycle high on a selected keyboard input sets the keyboard latch. The latch stays set until a write to address 4, whatever the data.
- R8: While rx_enable is 1, a receive count of 8 or more sets the serial-receive flag. The flag then stays set while the count is anywhere from 1 to 7.
- R9: The serial-receive flag clears when the receive count is 0, or when rx_enable is 0 in a cycle with ser_tick high.
- R10: The extension status register (address 2) holds the keyboard latch at bit 0, the receive flag at bit 1 and tx_int at bit 2, with the other bits 0. The extension mask (address 3, bits 2:0) gates these same bits onto irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| prim_src | input | 16 | Primary interrupt source levels |
| kbd_in | input | 8 | Keyboard port input lines |
| kbd_use8 | input | 1 | 1 = OR all eight lines, 0 = lowest six |
| rx_count | input | 5 | Receive FIFO fill count |
| rx_enable | input | 1 | Receiver enabled |
| ser_tick | input | 1 | One-cycle serial clock tick |
| tx_int | input | 1 | Serial transmit interrupt level |
| fiq | output | 1 | Registered fast interrupt request |
| irq | output | 1 | Registered normal interrupt request |

## Verification
The assertions check these behaviours on every cycle:

- the split of masked primary sources between fiq and irq, with its one-cycle lag;
- that the keyboard latch holds until an end-of-interrupt write;
- the set threshold of the receive flag and its clear on an empty FIFO;
- that the masks are clear after reset.

Only the bench scenarios can show the rest:

- the 6-line versus 8-line keyboard selection with a one-cycle glitch;
- the hysteresis of the receive flag between 1 and 7 entries;
- the clear by a serial tick after the receiver is disabled;
- the bit layout of the status registers;
- that writes to the status addresses leave state untouched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT_PRIM = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK_PRIM = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT_EXT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK_EXT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_KBD_EOI   = 3'd4;
  localparam int EXT_KBD = 0;
  localparam int EXT_RX  = 1;
  localparam int EXT_TX  = 2;
endpackage

// File: rtl/irq_kbd_latch.sv
module irq_kbd_latch #(
  parameter int KBD_W   = 8,
  parameter int KBD_LOW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KBD_W-1:0] kbd_in,
  input  logic             use_all,
  input  logic             eoi,
  output logic             flag
);
  localparam logic [KBD_W-1:0] LOW_SEL = KBD_W'((1 << KBD_LOW) - 1);
  localparam logic [KBD_W-1:0] ALL_SEL = '1;

  logic [KBD_W-1:0] sel;
  logic             hit;

  assign sel = use_all ? ALL_SEL : LOW_SEL;
  assign hit = |(kbd_in & sel);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (eoi) flag <= 1'b0;
  end
endmodule

// File: rtl/irq_rx_level.sv
module irq_rx_level #(
  parameter int CNT_W  = 5,
  parameter int THRESH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic             enable,
  input  logic             tick,
  output logic             flag
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

  logic empty, drop, rise;

  assign empty = (count == '0);
  assign drop  = !enable && tick;
  assign rise  = enable && (count >= THR);

  always_ff @(posedge clk) begin
    if (rst)                 flag <= 1'b0;
    else if (empty || drop)  flag <= 1'b0;
    else if (rise)           flag <= 1'b1;
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N_PRIM = 16,
  parameter int N_FIQ  = 4,
  parameter int N_EXT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PRIM-1:0] prim_stat,
  input  logic [N_PRIM-1:0] prim_mask,
  input  logic [N_EXT-1:0]  ext_stat,
  input  logic [N_EXT-1:0]  ext_mask,
  output logic              fiq,
  output logic              irq
);
  logic [N_PRIM-1:0] act;
  logic [N_PRIM-1:0] to_fast;
  logic [N_PRIM-1:0] to_norm;

  for (genvar i = 0; i < N_PRIM; i++) begin : g_route
    assign act[i] = prim_stat[i] & prim_mask[i];
    if (i < N_FIQ) begin : g_fast
      assign to_fast[i] = act[i];
      assign to_norm[i] = 1'b0;
    end else begin : g_norm
      assign to_fast[i] = 1'b0;
      assign to_norm[i] = act[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq <= 1'b0;
      irq <= 1'b0;
    end else begin
      fiq <= |to_fast;
      irq <= (|to_norm) | (|(ext_stat & ext_mask));
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_PRIM  = 16,
  parameter int N_FIQ   = 4,
  parameter int KBD_W   = 8,
  parameter int KBD_LOW = 6,
  parameter int CNT_W   = 5,
  parameter int RX_THR  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PRIM-1:0] bus_wdata,
  output logic [N_PRIM-1:0] bus_rdata,
  input  logic [N_PRIM-1:0] prim_src,
  input  logic [KBD_W-1:0]  kbd_in,
  input  logic              kbd_use8,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_enable,
  input  logic              ser_tick,
  input  logic              tx_int,
  output logic              fiq,
  output logic              irq
);
  localparam int N_EXT = 3;

  logic [N_PRIM-1:0] mask_prim;
  logic [N_EXT-1:0]  mask_ext;
  logic [N_EXT-1:0]  stat_ext;
  logic              kbd_flag, rx_flag, wr_en, rd_en, eoi_wr;

  assign wr_en  = bus_sel && bus_wr;
  assign rd_en  = bus_sel && !bus_wr;
  assign eoi_wr = wr_en && (bus_addr == A_KBD_EOI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_prim <= '0;
      mask_ext  <= '0;
    end else if (wr_en) begin
      if (bus_addr == A_MASK_PRIM) mask_prim <= bus_wdata;
      if (bus_addr == A_MASK_EXT)  mask_ext  <= bus_wdata[N_EXT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_en) begin
      case (bus_addr)
        A_STAT_PRIM: bus_rdata <= prim_src;
        A_MASK_PRIM: bus_rdata <= mask_prim;
        A_STAT_EXT:  bus_rdata <= N_PRIM'(stat_ext);
        A_MASK_EXT:  bus_rdata <= N_PRIM'(mask_ext);
        default:     bus_rdata <= '0;
      endcase
    end
  end

  irq_kbd_latch #(.KBD_W(KBD_W), .KBD_LOW(KBD_LOW)) u_kbd (
    .clk(clk), .rst(rst), .kbd_in(kbd_in), .use_all(kbd_use8),
    .eoi(eoi_wr), .flag(kbd_flag)
  );

  irq_rx_level #(.CNT_W(CNT_W), .THRESH(RX_THR)) u_rx (
    .clk(clk), .rst(rst), .count(rx_count), .enable(rx_enable),
    .tick(ser_tick), .flag(rx_flag)
  );

  always_comb begin
    stat_ext          = '0;
    stat_ext[EXT_KBD] = kbd_flag;
    stat_ext[EXT_RX]  = rx_flag;
    stat_ext[EXT_TX]  = tx_int;
  end

  irq_combine #(.N_PRIM(N_PRIM), .N_FIQ(N_FIQ), .N_EXT(N_EXT)) u_comb (
    .clk(clk), .rst(rst), .prim_stat(prim_src), .prim_mask(mask_prim),
    .ext_stat(stat_ext), .ext_mask(mask_ext), .fiq(fiq), .irq(irq)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_PRIM = 16,
  parameter int N_FIQ  = 4,
  parameter int CNT_W  = 5,
  parameter int RX_THR = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_PRIM-1:0] prim_src,
  input logic [N_PRIM-1:0] mask_prim,
  input logic [2:0]        mask_ext,
  input logic              fiq,
  input logic              irq,
  input logic              kbd_flag,
  input logic              eoi_wr,
  input logic              rx_enable,
  input logic [CNT_W-1:0]  rx_count,
  input logic              rx_flag
);
  logic fast_any, norm_any;
  assign fast_any = |(prim_src[N_FIQ-1:0] & mask_prim[N_FIQ-1:0]);
  assign norm_any = |(prim_src[N_PRIM-1:N_FIQ] & mask_prim[N_PRIM-1:N_FIQ]);

  a_r1_mask_reset: assert property (@(posedge clk)
    rst |=> (mask_prim == '0 && mask_ext == '0 && !fiq && !irq));

  a_r3_fiq_raise: assert property (@(posedge clk) disable iff (rst)
    fast_any |=> fiq);

  a_r3_fiq_idle: assert property (@(posedge clk) disable iff (rst)
    !fast_any |=> !fiq);

  a_r4_irq_raise: assert property (@(posedge clk) disable iff (rst)
    norm_any |=> irq);

  a_r7_kbd_hold: assert property (@(posedge clk) disable iff (rst)
    (kbd_flag && !eoi_wr) |=> kbd_flag);

  a_r8_rx_rise: assert property (@(posedge clk) disable iff (rst)
    (rx_enable && rx_count >= CNT_W'(RX_THR)) |=> rx_flag);

  a_r9_rx_empty: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |=> !rx_flag);
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N_PRIM(N_PRIM), .N_FIQ(N_FIQ), .CNT_W(CNT_W), .RX_THR(RX_THR)
) u_chk (
  .clk(clk), .rst(rst), .prim_src(prim_src), .mask_prim(mask_prim),
  .mask_ext(mask_ext), .fiq(fiq), .irq(irq), .kbd_flag(kbd_flag),
  .eoi_wr(eoi_wr), .rx_enable(rx_enable), .rx_count(rx_count),
  .rx_flag(rx_flag)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [15:0] prim_src = '0;
  logic [7:0]  kbd_in = '0;
  logic        kbd_use8 = 1'b0;
  logic [4:0]  rx_count = '0;
  logic        rx_enable = 1'b0, ser_tick = 1'b0, tx_int = 1'b0;
  logic        fiq, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prim_src(prim_src), .kbd_in(kbd_in), .kbd_use8(kbd_use8),
    .rx_count(rx_count), .rx_enable(rx_enable), .ser_tick(ser_tick),
    .tx_int(tx_int), .fiq(fiq), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(logic [2:0] a, logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [15:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 fiq after reset", 16'(fiq), 16'h0);
    check("R1 irq after reset", 16'(irq), 16'h0);
    bus_read(3'd1, d); check("R1 prim mask reset", d, 16'h0);
    bus_read(3'd3, d); check("R1 ext mask reset", d, 16'h0);
  endtask

  task automatic t_mask_rw();
    logic [15:0] d;
    bus_write(3'd1, 16'hA5C3);
    bus_read(3'd1, d); check("R2 mask readback", d, 16'hA5C3);
    bus_write(3'd1, 16'h0000);
  endtask

  task automatic t_fast();
    bus_write(3'd1, 16'h000F);
    prim_src = 16'h0004; wait_n(1);
    check("R3 fiq raised", 16'(fiq), 16'h1);
    check("R3 irq quiet", 16'(irq), 16'h0);
    bus_write(3'd1, 16'h000B); wait_n(1);
    check("R3 masked fast source", 16'(fiq), 16'h0);
    prim_src = 16'h0000; bus_write(3'd1, 16'h0);
  endtask

  task automatic t_norm();
    bus_write(3'd1, 16'hFFF0);
    prim_src = 16'h0100; wait_n(1);
    check("R4 irq raised", 16'(irq), 16'h1);
    check("R4 fiq quiet", 16'(fiq), 16'h0);
    prim_src = 16'h0000; wait_n(1);
    check("R4 irq dropped", 16'(irq), 16'h0);
    bus_write(3'd1, 16'h0);
  endtask

  task automatic t_status();
    logic [15:0] d;
    bus_write(3'd1, 16'h1234);
    prim_src = 16'h8421;
    bus_read(3'd0, d); check("R5 raw status", d, 16'h8421);
    bus_write(3'd0, 16'hFFFF);
    bus_write(3'd2, 16'hFFFF);
    bus_read(3'd1, d); check("R5 mask untouched", d, 16'h1234);
    bus_read(3'd0, d); check("R5 status unchanged", d, 16'h8421);
    bus_read(3'd3, d); check("R5 ext mask untouched", d, 16'h0);
    prim_src = 16'h0; bus_write(3'd1, 16'h0); wait_n(1);
  endtask

  task automatic t_kbd();
    logic [15:0] d;
    bus_write(3'd3, 16'h0001);
    kbd_use8 = 0; kbd_in = 8'h80; wait_n(1); kbd_in = 8'h00; wait_n(2);
    check("R6 line 7 ignored in 6-line mode", 16'(irq), 16'h0);
    bus_read(3'd2, d); check("R6 kbd status clear", d, 16'h0000);
    kbd_use8 = 1; kbd_in = 8'h80; wait_n(1); kbd_in = 8'h00; wait_n(1);
    check("R6 line 7 in 8-line mode", 16'(irq), 16'h1);
    wait_n(5);
    check("R7 latch holds", 16'(irq), 16'h1);
    bus_read(3'd2, d); check("R7 kbd status bit0", d, 16'h0001);
    bus_write(3'd4, 16'h0000); wait_n(1);
    check("R7 eoi clears", 16'(irq), 16'h0);
    kbd_use8 = 0; kbd_in = 8'h01; wait_n(1); kbd_in = 8'h00; wait_n(1);
    check("R6 line 0 in 6-line mode", 16'(irq), 16'h1);
    bus_write(3'd4, 16'hFFFF); wait_n(1);
    check("R7 eoi clears again", 16'(irq), 16'h0);
    bus_write(3'd3, 16'h0);
  endtask

  task automatic t_rx();
    logic [15:0] d;
    bus_write(3'd3, 16'h0002);
    rx_enable = 1; rx_count = 5'd7; wait_n(2);
    check("R8 below threshold", 16'(irq), 16'h0);
    rx_count = 5'd8; wait_n(2);
    check("R8 at threshold", 16'(irq), 16'h1);
    rx_count = 5'd3; wait_n(3);
    check("R8 held while partly full", 16'(irq), 16'h1);
    bus_read(3'd2, d); check("R10 rx at bit1", d, 16'h0002);
    rx_count = 5'd0; wait_n(2);
    check("R9 clear on empty", 16'(irq), 16'h0);
    rx_count = 5'd9; wait_n(2);
    rx_enable = 0; wait_n(3);
    check("R9 held until tick", 16'(irq), 16'h1);
    ser_tick = 1; wait_n(1); ser_tick = 0; wait_n(1);
    check("R9 clear on tick when disabled", 16'(irq), 16'h0);
    rx_count = 5'd0; bus_write(3'd3, 16'h0);
  endtask

  task automatic t_ext();
    logic [15:0] d;
    tx_int = 1; wait_n(1);
    check("R10 tx unmasked quiet", 16'(irq), 16'h0);
    bus_write(3'd3, 16'h0004); wait_n(1);
    check("R10 tx drives irq", 16'(irq), 16'h1);
    bus_read(3'd2, d); check("R10 tx at bit2", d, 16'h0004);
    bus_read(3'd3, d); check("R10 ext mask readback", d, 16'h0004);
    tx_int = 0; wait_n(2);
    check("R10 tx drop", 16'(irq), 16'h0);
    bus_write(3'd3, 16'h0);
  endtask

  initial begin
    wait_n(3);
    rst = 0;
    wait_n(1);
    t_reset();
    t_mask_rw();
    t_fast();
    t_norm();
    t_status();
    t_kbd();
    t_rx();
    t_ext();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule